// File: doc/BRIEF.md
# Variable-Page TLB Lookup and Fault Classifier

This block translates a 32-bit virtual address to a physical address. It searches a small, fully associative table of translation entries, and each entry may map a 1 KB, 4 KB, 64 KB or 1 MB page. An entry takes part in the search only when it is valid and its address-space tag is acceptable. The tag is acceptable when it equals the current tag, when the entry is marked global, or when tag checking is switched off. Tag checking is switched off only when a supervisor request is made with single-address-space mode enabled.

After the search, the block classifies the outcome as one of the following: a successful translation, a miss, more than one matching entry, a protection violation, or a first write to a clean page. Each outcome has a fixed 12-bit exception code. Two fixed windows of the address space skip translation. User-mode access to these windows is rejected, apart from a small window kept for store buffers. When translation is disabled, the block folds addresses to 29 bits.

The response is registered and appears one cycle after the request. With each response the block records the faulting address and, for most faults, the faulting page number, so that a refill handler can use them. A replacement counter advances on every access that goes through the table, and it wraps under a programmable limit. Entries are written through a simple indexed load port.

Top module: `vpt_lookup`

## Requirements
- R1: The entry size code selects the page: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. An entry matches when the virtual address bits above the page offset equal the entry page number shifted left by 10 bits, with the bits below the page size ignored.
- R2: On a successful translation, the physical address takes its bits above the page offset from the entry frame number shifted left by 10 bits, and its bits below the page size from the virtual address.
- R3: An entry whose valid bit is 0 never matches. An entry whose tag differs from `cur_asid` matches only if its global bit is 1 or tag checking is off.
- R4: Tag checking is off only when `req_priv` = 1 and `single_space` = 1.
- R5: Two or more matching entries give code 0x140. In that case `fault_vpn` is left unchanged.
- R6: Access kind encoding is 0 = read, 1 = write, 2 = fetch. Protection bit 1 permits user access, and protection bit 0 permits writes. For a read or write on a hit, a user access without bit 1 gives 0x0A0 (read) or 0x0C0 (write). If the access is allowed for the user, a write without bit 0 gives 0x0C0.
- R7: A write that passes protection but hits an entry with dirty = 0 gives 0x080. A read of the same page succeeds.
- R8: A miss gives 0x040 for a read or fetch and 0x060 for a write. A user fetch from a page without protection bit 1 gives 0x0A0.
- R9: `urc` advances by one on each table access. It wraps to 0 when the incremented value exceeds a nonzero `urb_limit`, or exceeds ENTRIES-1. Requests that do not use the table leave it unchanged.
- R10: Addresses with top bits 10 (0x80000000-0xBFFFFFFF) skip the table and map to their low 29 bits. Addresses from 0xE0000000 upward skip the table and pass unchanged. A user access to either window gives 0x0E0 (read or fetch) or 0x100 (write), except for 0xE0000000-0xE3FFFFFF, which is allowed.
- R11: With `xlat_en` = 0, an address outside the fixed windows maps to its low 29 bits with full permission.
- R12: On any nonzero code, `fault_va` takes the request address. On any nonzero code other than 0x140, `fault_vpn` takes address bits [31:10].
- R13: `rsp_valid` is high exactly one cycle after `req_valid`, including for back-to-back requests. Code 0 means success. When the code is nonzero, `rsp_pa` is 0.
- R14: After reset, `rsp_valid`, `urc`, `fault_va` and `fault_vpn` are 0 and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Supervisor mode |
| xlat_en | input | 1 | Translation enable |
| single_space | input | 1 | Single-address-space mode |
| cur_asid | input | 8 | Current address-space tag |
| urb_limit | input | 6 | Counter wrap limit, 0 = none |
| ld_en | input | 1 | Entry load strobe |
| ld_idx | input | 6 | Entry index to load |
| ld_valid | input | 1 | Loaded valid bit |
| ld_global | input | 1 | Loaded global (tag-free) bit |
| ld_asid | input | 8 | Loaded tag |
| ld_vpn | input | 22 | Loaded page number |
| ld_ppn | input | 19 | Loaded frame number |
| ld_size | input | 2 | Loaded size code |
| ld_prot | input | 2 | Loaded protection bits |
| ld_dirty | input | 1 | Loaded dirty bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 12 | Exception code, 0 = success |
| urc | output | 6 | Replacement counter |
| fault_vpn | output | 22 | Captured faulting page number |
| fault_va | output | 32 | Captured faulting address |

## Verification
The table of lookups uses one entry of each page size and probes addresses just inside and just outside each page, which shows whether the mask follows the size code. Each page is hit with all three access kinds in both privilege modes, so that every branch of the protection, dirty and miss ordering is exercised. The same address is also tried with a matching tag, a foreign tag, a global entry and tag checking switched off, which separates the tag rules. Two overlapping entries trigger the multiple-hit path. Bypass-window addresses, including the edges of the store-buffer window, are tried in each privilege mode with translation both on and off. The replacement counter is followed across several wraps, first with no limit and then with a small limit.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    localparam int VA_W   = 32;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int CNT_W  = 6;
    localparam int CODE_W = 12;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic              dirty;
    } tlb_ent_t;

    localparam logic [CODE_W-1:0] CODE_OK       = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MISS_RD  = 12'h040;
    localparam logic [CODE_W-1:0] CODE_MISS_WR  = 12'h060;
    localparam logic [CODE_W-1:0] CODE_FIRST_WR = 12'h080;
    localparam logic [CODE_W-1:0] CODE_PROT_RD  = 12'h0A0;
    localparam logic [CODE_W-1:0] CODE_PROT_WR  = 12'h0C0;
    localparam logic [CODE_W-1:0] CODE_ADDR_RD  = 12'h0E0;
    localparam logic [CODE_W-1:0] CODE_ADDR_WR  = 12'h100;
    localparam logic [CODE_W-1:0] CODE_MULTI    = 12'h140;

    localparam logic [1:0] KIND_WRITE = 2'd1;

    // in-page offset mask selected by the size code
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    page_mask = 32'h0000_03FF;
            2'd1:    page_mask = 32'h0000_0FFF;
            2'd2:    page_mask = 32'h0000_FFFF;
            default: page_mask = 32'h000F_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/vpt_match_array.sv
module vpt_match_array
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_ent_t [ENTRIES-1:0] ent_i,
    input  logic [VA_W-1:0]        va_i,
    input  logic [ASID_W-1:0]      asid_i,
    input  logic                   tag_chk_i,
    output logic                   any_o,
    output logic                   multi_o,
    output logic [PPN_W-1:0]       ppn_o,
    output logic [1:0]             size_o,
    output logic [1:0]             prot_o,
    output logic                   dirty_o
);

    localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

    logic [ENTRIES-1:0] hit;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] mask;
        logic            tag_ok;
        assign base   = {ent_i[g].vpn, 10'b0};
        assign mask   = page_mask(ent_i[g].size);
        assign tag_ok = !tag_chk_i || ent_i[g].glob || (ent_i[g].asid == asid_i);
        assign hit[g] = ent_i[g].valid && tag_ok && (((va_i ^ base) & ~mask) == '0);
    end

    always_comb begin
        any_o   = |hit;
        multi_o = (hit & (hit - ONE)) != '0;
        ppn_o   = '0;
        size_o  = '0;
        prot_o  = '0;
        dirty_o = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit[i]) begin
                ppn_o   |= ent_i[i].ppn;
                size_o  |= ent_i[i].size;
                prot_o  |= ent_i[i].prot;
                dirty_o |= ent_i[i].dirty;
            end
        end
    end

endmodule

// File: rtl/vpt_classify.sv
module vpt_classify
    import vpt_pkg::*;
(
    input  logic [VA_W-1:0]   va_i,
    input  logic [1:0]        kind_i,
    input  logic              priv_i,
    input  logic              xlat_en_i,
    input  logic              any_i,
    input  logic              multi_i,
    input  logic [PPN_W-1:0]  ppn_i,
    input  logic [1:0]        size_i,
    input  logic [1:0]        prot_i,
    input  logic              dirty_i,
    output logic [CODE_W-1:0] code_o,
    output logic [VA_W-1:0]   pa_o,
    output logic              tbl_used_o
);

    logic            is_wr;
    logic            win_low;
    logic            win_high;
    logic            win_sq;
    logic [VA_W-1:0] mask;
    logic [VA_W-1:0] frame;

    always_comb begin
        is_wr      = (kind_i == KIND_WRITE);
        win_low    = (va_i[31:30] == 2'b10);
        win_high   = (va_i[31:29] == 3'b111);
        win_sq     = (va_i[31:26] == 6'b111000);
        mask       = page_mask(size_i);
        frame      = {3'b000, ppn_i, 10'b0};
        code_o     = CODE_OK;
        pa_o       = '0;
        tbl_used_o = 1'b0;
        if (win_low || win_high) begin
            if (!priv_i && !win_sq) begin
                code_o = is_wr ? CODE_ADDR_WR : CODE_ADDR_RD;
            end else begin
                pa_o = win_low ? {3'b000, va_i[28:0]} : va_i;
            end
        end else if (!xlat_en_i) begin
            pa_o = {3'b000, va_i[28:0]};
        end else begin
            tbl_used_o = 1'b1;
            if (multi_i) begin
                code_o = CODE_MULTI;
            end else if (!any_i) begin
                code_o = is_wr ? CODE_MISS_WR : CODE_MISS_RD;
            end else if (!priv_i && !prot_i[1]) begin
                code_o = is_wr ? CODE_PROT_WR : CODE_PROT_RD;
            end else if (is_wr && !prot_i[0]) begin
                code_o = CODE_PROT_WR;
            end else if (is_wr && !dirty_i) begin
                code_o = CODE_FIRST_WR;
            end else begin
                pa_o = (frame & ~mask) | (va_i & mask);
            end
        end
    end

endmodule

// File: rtl/vpt_urc_step.sv
module vpt_urc_step
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [CNT_W-1:0] cur_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] nxt_o
);

    localparam logic [CNT_W:0] LAST = (CNT_W+1)'(ENTRIES - 1);

    logic [CNT_W:0] inc;

    always_comb begin
        inc = {1'b0, cur_i} + 1'b1;
        if (!adv_i) begin
            nxt_o = cur_i;
        end else if (((limit_i != '0) && (inc > {1'b0, limit_i})) || (inc > LAST)) begin
            nxt_o = '0;
        end else begin
            nxt_o = inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/vpt_lookup.sv
module vpt_lookup
    import vpt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic [1:0]  req_kind,
    input  logic        req_priv,
    input  logic        xlat_en,
    input  logic        single_space,
    input  logic [7:0]  cur_asid,
    input  logic [5:0]  urb_limit,
    input  logic        ld_en,
    input  logic [5:0]  ld_idx,
    input  logic        ld_valid,
    input  logic        ld_global,
    input  logic [7:0]  ld_asid,
    input  logic [21:0] ld_vpn,
    input  logic [18:0] ld_ppn,
    input  logic [1:0]  ld_size,
    input  logic [1:0]  ld_prot,
    input  logic        ld_dirty,
    output logic        rsp_valid,
    output logic [31:0] rsp_pa,
    output logic [11:0] rsp_fault,
    output logic [5:0]  urc,
    output logic [21:0] fault_vpn,
    output logic [31:0] fault_va
);

    typedef struct packed {
        logic              rsp_valid;
        logic [VA_W-1:0]   pa;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  urc;
        logic [VPN_W-1:0]  fvpn;
        logic [VA_W-1:0]   fva;
    } state_t;

    state_t                st_d, st_q;
    tlb_ent_t [ENTRIES-1:0] ent_q;
    tlb_ent_t              ld_ent;

    logic              any_hit, multi_hit, hit_dirty, tbl_used;
    logic [PPN_W-1:0]  hit_ppn;
    logic [1:0]        hit_size, hit_prot;
    logic [CODE_W-1:0] code;
    logic [VA_W-1:0]   pa;
    logic [CNT_W-1:0]  urc_nxt;

    assign ld_ent = '{valid: ld_valid, glob: ld_global, asid: ld_asid, vpn: ld_vpn,
                      ppn: ld_ppn, size: ld_size, prot: ld_prot, dirty: ld_dirty};

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (ld_en && (ld_idx == CNT_W'(i))) begin
                ent_q[i] <= ld_ent;
            end
        end
    end

    vpt_match_array #(.ENTRIES(ENTRIES)) u_match (
        .ent_i     (ent_q),
        .va_i      (req_va),
        .asid_i    (cur_asid),
        .tag_chk_i (!(single_space && req_priv)),
        .any_o     (any_hit),
        .multi_o   (multi_hit),
        .ppn_o     (hit_ppn),
        .size_o    (hit_size),
        .prot_o    (hit_prot),
        .dirty_o   (hit_dirty)
    );

    vpt_classify u_class (
        .va_i       (req_va),
        .kind_i     (req_kind),
        .priv_i     (req_priv),
        .xlat_en_i  (xlat_en),
        .any_i      (any_hit),
        .multi_i    (multi_hit),
        .ppn_i      (hit_ppn),
        .size_i     (hit_size),
        .prot_i     (hit_prot),
        .dirty_i    (hit_dirty),
        .code_o     (code),
        .pa_o       (pa),
        .tbl_used_o (tbl_used)
    );

    vpt_urc_step #(.ENTRIES(ENTRIES)) u_urc (
        .cur_i   (st_q.urc),
        .limit_i (urb_limit),
        .adv_i   (req_valid && tbl_used),
        .nxt_o   (urc_nxt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        if (req_valid) begin
            st_d.pa   = pa;
            st_d.code = code;
            st_d.urc  = urc_nxt;
            if (code != CODE_OK) begin
                st_d.fva = req_va;
                if (code != CODE_MULTI) begin
                    st_d.fvpn = req_va[31:10];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_pa    = st_q.pa;
    assign rsp_fault = st_q.code;
    assign urc       = st_q.urc;
    assign fault_vpn = st_q.fvpn;
    assign fault_va  = st_q.fva;

endmodule

// File: rtl/vpt_lookup_chk.sv
module vpt_lookup_chk #(
    parameter int ENTRIES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_va,
    input logic [1:0]  req_kind,
    input logic        req_priv,
    input logic        rsp_valid,
    input logic [31:0] rsp_pa,
    input logic [11:0] rsp_fault,
    input logic [5:0]  urc,
    input logic [21:0] fault_vpn,
    input logic [31:0] fault_va
);

    // R13
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R13
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R13
    fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 12'h000) |-> (rsp_pa == 32'h0));

    // R9
    urc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urc <= 6'(ENTRIES - 1));

    // R9
    urc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(urc));

    // R12
    fault_va_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 12'h000) |-> (fault_va == $past(req_va)));

    // R5
    multi_keeps_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 12'h140) |-> $stable(fault_vpn));

    // R10
    user_low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && req_va[31:30] == 2'b10)
        |=> (rsp_fault == ($past(req_kind) == 2'd1 ? 12'h100 : 12'h0E0)));

endmodule

bind vpt_lookup vpt_lookup_chk #(.ENTRIES(ENTRIES)) u_vpt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_va    (req_va),
    .req_kind  (req_kind),
    .req_priv  (req_priv),
    .rsp_valid (rsp_valid),
    .rsp_pa    (rsp_pa),
    .rsp_fault (rsp_fault),
    .urc       (urc),
    .fault_vpn (fault_vpn),
    .fault_va  (fault_va)
);

// File: tb/test_vpt_lookup.sv
module test_vpt_lookup;

    localparam int ENTRIES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        xlat_en = 1'b0;
    logic        single_space = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic [5:0]  urb_limit = '0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_idx = '0;
    logic        ld_valid = 1'b0, ld_global = 1'b0, ld_dirty = 1'b0;
    logic [7:0]  ld_asid = '0;
    logic [21:0] ld_vpn = '0;
    logic [18:0] ld_ppn = '0;
    logic [1:0]  ld_size = '0, ld_prot = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [11:0] rsp_fault;
    logic [5:0]  urc;
    logic [21:0] fault_vpn;
    logic [31:0] fault_va;

    vpt_lookup #(.ENTRIES(ENTRIES)) i_vpt_lookup (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [5:0]  e_urc  = '0;
    logic [21:0] e_fvpn = '0;
    logic [31:0] e_fva  = '0;

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        priv;
        logic        xlat;
        logic        sv;
        logic [7:0]  asid;
        logic [11:0] code;
        logic [31:0] pa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0123, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0040_0123, 4'd1}, // R1 1K hit
        '{32'h0001_0400, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h040, 32'h0,         4'd1}, // R1 past 1K page
        '{32'h0002_0ABC, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0050_0ABC, 4'd3}, // R3 global entry
        '{32'h0002_0FFF, 2'd0, 1'b0, 1'b1, 1'b0, 8'h22, 12'h000, 32'h0050_0FFF, 4'd1}, // R1 4K top
        '{32'h0010_FFFE, 2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 12'h000, 32'h00A0_FFFE, 4'd2}, // R2 64K
        '{32'h0010_1000, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0A0, 32'h0,         4'd6}, // R6 user read
        '{32'h0010_1000, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0C0, 32'h0,         4'd6}, // R6 user write
        '{32'h0010_1000, 2'd1, 1'b1, 1'b1, 1'b0, 8'h11, 12'h000, 32'h00A0_1000, 4'd6}, // R6 priv write ok
        '{32'h004A_BCDE, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h010A_BCDE, 4'd1}, // R1 1M
        '{32'h0040_0000, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0C0, 32'h0,         4'd6}, // R6 read-only
        '{32'h0040_0000, 2'd1, 1'b1, 1'b1, 1'b0, 8'h11, 12'h0C0, 32'h0,         4'd6}, // R6 priv read-only
        '{32'h0040_0010, 2'd2, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0100_0010, 4'd8}, // R8 fetch ok
        '{32'h0010_0010, 2'd2, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0A0, 32'h0,         4'd8}, // R8 user fetch
        '{32'h0003_0010, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 12'h080, 32'h0,         4'd7}, // R7 clean write
        '{32'h0003_0010, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0060_0010, 4'd7}, // R7 clean read
        '{32'h0004_0010, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h040, 32'h0,         4'd3}, // R3 foreign tag
        '{32'h0004_0010, 2'd0, 1'b0, 1'b1, 1'b0, 8'h33, 12'h000, 32'h0070_0010, 4'd3}, // R3 own tag
        '{32'h0004_0010, 2'd0, 1'b1, 1'b1, 1'b1, 8'h11, 12'h000, 32'h0070_0010, 4'd4}, // R4 tag off
        '{32'h0004_0010, 2'd0, 1'b0, 1'b1, 1'b1, 8'h11, 12'h040, 32'h0,         4'd4}, // R4 user keeps tag
        '{32'h0005_0000, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 12'h060, 32'h0,         4'd8}, // R8 write miss
        '{32'h0005_0000, 2'd2, 1'b0, 1'b1, 1'b0, 8'h11, 12'h040, 32'h0,         4'd8}, // R8 fetch miss
        '{32'h0020_1234, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h140, 32'h0,         4'd5}, // R5 overlap
        '{32'h0020_F00F, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0080_F00F, 4'd2}, // R2 single hit
        '{32'h8ABC_DEF0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0ABC_DEF0, 4'd10}, // R10
        '{32'hA123_4567, 2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0123_4567, 4'd10}, // R10
        '{32'hC000_0010, 2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 12'h040, 32'h0,         4'd10}, // R10 translated
        '{32'hF000_1234, 2'd0, 1'b1, 1'b1, 1'b0, 8'h11, 12'h000, 32'hF000_1234, 4'd10}, // R10
        '{32'h8000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0E0, 32'h0,         4'd10}, // R10
        '{32'hA000_0000, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 12'h100, 32'h0,         4'd10}, // R10
        '{32'hFF00_0000, 2'd2, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0E0, 32'h0,         4'd10}, // R10
        '{32'hE000_0040, 2'd1, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'hE000_0040, 4'd10}, // R10 window
        '{32'hE400_0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h0E0, 32'h0,         4'd10}, // R10 past window
        '{32'h7234_5678, 2'd0, 1'b0, 1'b0, 1'b0, 8'h11, 12'h000, 32'h1234_5678, 4'd11}, // R11
        '{32'h0010_1000, 2'd1, 1'b0, 1'b0, 1'b0, 8'h11, 12'h000, 32'h0010_1000, 4'd11}, // R11
        '{32'h8000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 8'h11, 12'h0E0, 32'h0,         4'd11}, // R11 window first
        '{32'hC000_0010, 2'd0, 1'b1, 1'b0, 1'b0, 8'h11, 12'h000, 32'h0000_0010, 4'd11}  // R11
    };

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [5:0] urc_model(input logic [5:0] cur, input logic [5:0] lim);
        logic [6:0] inc = {1'b0, cur} + 7'd1;
        if ((lim != 0 && inc > {1'b0, lim}) || inc > 7'(ENTRIES - 1)) return 6'd0;
        return inc[5:0];
    endfunction

    task automatic load(input int idx, input logic v, input logic gl, input logic [7:0] asid,
                        input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                        input logic [1:0] pr, input logic d);
        ld_en = 1'b1; ld_idx = 6'(idx); ld_valid = v; ld_global = gl; ld_asid = asid;
        ld_vpn = va[31:10]; ld_ppn = pa[28:10]; ld_size = sz; ld_prot = pr; ld_dirty = d;
        @(posedge clk); @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1; req_va = v.va; req_kind = v.kind; req_priv = v.priv;
        xlat_en = v.xlat; single_space = v.sv; cur_asid = v.asid;
    endtask

    task automatic expect_rsp(input vec_t v);
        string rq;
        logic  used;
        rq = $sformatf("R%0d", v.rq);
        used = v.xlat && !(v.va[31:30] == 2'b10) && !(v.va[31:29] == 3'b111);
        if (used) e_urc = urc_model(e_urc, urb_limit);
        if (v.code != 12'h000) begin
            e_fva = v.va;
            if (v.code != 12'h140) e_fvpn = v.va[31:10];
        end
        check("R13", "rsp_valid", 32'(rsp_valid), 32'd1);
        check(rq, $sformatf("code @%h", v.va), 32'(rsp_fault), 32'(v.code));
        check(rq, $sformatf("pa @%h", v.va), rsp_pa, v.pa);
        check("R9", "urc", 32'(urc), 32'(e_urc));
        check("R12", "fault_va", fault_va, e_fva);
        check("R12", "fault_vpn", 32'(fault_vpn), 32'(e_fvpn));
    endtask

    task automatic one_req(input vec_t v);
        drive(v);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        expect_rsp(v);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL R13 watchdog: actual %0d cycles expected fewer than 100000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        vec_t t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R14 reset state
        check("R14", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R14", "urc", 32'(urc), 32'd0);
        check("R14", "fault_va", fault_va, 32'd0);
        check("R14", "fault_vpn", 32'(fault_vpn), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 no valid entries yet: translated read misses
        one_req('{32'h0001_0123, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h040, 32'h0, 4'd14});

        load(0, 1, 0, 8'h11, 32'h0001_0000, 32'h0040_0000, 2'd0, 2'b11, 1);
        load(1, 1, 1, 8'h22, 32'h0002_0000, 32'h0050_0000, 2'd1, 2'b11, 1);
        load(2, 1, 0, 8'h11, 32'h0010_0000, 32'h00A0_0000, 2'd2, 2'b01, 1);
        load(3, 1, 0, 8'h11, 32'h0040_0000, 32'h0100_0000, 2'd3, 2'b10, 1);
        load(4, 1, 0, 8'h11, 32'h0003_0000, 32'h0060_0000, 2'd1, 2'b11, 0);
        load(5, 1, 0, 8'h33, 32'h0004_0000, 32'h0070_0000, 2'd1, 2'b11, 1);
        load(6, 1, 0, 8'h11, 32'h0020_0000, 32'h0080_0000, 2'd2, 2'b11, 1);
        load(7, 1, 0, 8'h11, 32'h0020_1000, 32'h0090_0000, 2'd1, 2'b11, 1);

        for (int i = 0; i < NV; i++) one_req(VECS[i]);

        // R13 idle cycle after the walk
        @(negedge clk);
        check("R13", "idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R13 back-to-back requests
        t = '{32'h0001_0004, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0040_0004, 4'd13};
        drive(t);
        @(posedge clk); @(negedge clk);
        expect_rsp(t);
        t = '{32'h0020_F000, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0080_F000, 4'd13};
        drive(t);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        expect_rsp(t);

        // R9 wrap under a nonzero limit
        urb_limit = 6'd2;
        for (int k = 0; k < 6; k++)
            one_req('{32'h0001_0010, 2'd0, 1'b0, 1'b1, 1'b0, 8'h11, 12'h000, 32'h0040_0010, 4'd9});
        urb_limit = 6'd0;

        // R3 invalidated entry no longer matches, even with tag checking off
        load(5, 0, 0, 8'h33, 32'h0004_0000, 32'h0070_0000, 2'd1, 2'b11, 1);
        one_req('{32'h0004_0010, 2'd0, 1'b1, 1'b1, 1'b1, 8'h33, 12'h040, 32'h0, 4'd3});

        summary();
        $finish;
    end

endmodule